// File: doc/BRIEF.md
# Programmable Peripheral Trigger Sequencer

This block runs a small program of 8-bit step commands held in a 32-entry queue. It needs no processor. A program can stall on a hardware or software trigger event, or wait out a delay on one of two 16-bit timers. It can also run a counted loop, jump, pulse any of 32 output trigger lines, and raise any of 16 interrupt request lines. A watchdog catches a trigger that never arrives, and a single-step control bit lets software advance the program one command at a time.

Software programs the block through a register port. The port gives access to the queue words, the timer and loop limits, the trigger input configuration, the watchdog limit and the control bits. A read-only status word shows the queue pointer and the mode bits. Register map, in word addresses: 0–7 queue words, 8 control, 9 timer 0 limit, 10 timer 1 limit, 11 loop limit, 12 trigger configuration, 13 watchdog limit, 14 status. Control holds ON in bit 0, START in bit 1, single-step enable in bit 2 and the pulse width code in bits [5:4]. Status holds the pointer in [4:0], ON in bit 8, START in bit 9 and single-step in bit 10.

Top module: `trig_seq`

## Requirements
- R1: Queue entry 4k+i is held in bits [8i+7:8i] of queue word k, and reads back there. An entry's op code is bits [7:4] and its operand is bits [3:0]. Op codes: 0 no-op, 1 wait for hardware input, 2 wait for software trigger, 3 timer wait (operand bit 0 selects the timer), 4 pulse line operand, 5 pulse line 16+operand, 6 IRQ operand, 7 jump to operand, 8 jump to 16+operand, 9 counted jump to operand, 10 counted jump to 16+operand, 11–15 no-op. Every command that does not wait finishes in one clock.
- R2: A wait for a hardware input stalls until that input's event occurs. Bit n of configuration bits [15:0] selects edge mode (1) or level mode (0) for input n. Bit 16+n inverts the input.
- R3: A wait for the software trigger stalls until sw_trig is sampled high.
- R4: A timer wait holds the pointer for LIMIT+1 clocks and then moves on.
- R5: A pulse command drives its output line high for (code+1) clocks, starting one clock after the command runs. The code is control bits [5:4].
- R6: An IRQ command drives irq_out[operand] high for exactly one clock, one clock after the command runs. At most one IRQ line is high at a time.
- R7: A counted jump with loop limit N is taken N times and then falls through, so the loop body runs N+1 times. A plain jump loads the pointer directly.
- R8: START can only be set from Halt (ON already 1). A write that sets ON and START together leaves START clear. Clearing ON resets the pointer, timers, loop counter and watchdog.
- R9: While Running, writes to the queue, limits, configuration and watchdog limit are ignored. A control write while Running only acts when it clears ON.
- R10: With single-step enabled, each setting of START runs one command. START then clears and step_irq pulses for one clock.
- R11: With a nonzero watchdog limit W, a wait that stalls for W+1 clocks pulses wdog_irq, clears START and leaves the pointer on the stalled command.
- R12: The pointer wraps from 31 to 0. Status shows the pointer and the mode bits, with rd_data valid one clock after rd_addr.
- R13: After reset all outputs are low and status reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read word address |
| rd_data | output | 32 | Registered read data |
| hw_trig | input | 16 | Hardware trigger inputs |
| sw_trig | input | 1 | Software trigger |
| trig_out | output | 32 | Output trigger pulses |
| irq_out | output | 16 | Individual interrupt requests |
| step_irq | output | 1 | Single-step completion pulse |
| wdog_irq | output | 1 | Watchdog timeout pulse |

## Verification
A command takes effect at the clock edge where the pointer addresses it while Running. Its trigger, IRQ, step and watchdog outputs appear one edge later, and register reads return one edge after rd_addr. The bench holds a behavioural model that advances at the same posedge the design samples. It compares all four output groups at every negedge, half a cycle after each edge. Directed checks measure timer delays as the gap between first-rise cycles of two output lines. They also read status after the design has settled, so no check depends on where in the cycle a stimulus lands.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam logic [3:0] OP_NOP     = 4'd0;
  localparam logic [3:0] OP_WAIT_HW = 4'd1;
  localparam logic [3:0] OP_WAIT_SW = 4'd2;
  localparam logic [3:0] OP_TWAIT   = 4'd3;
  localparam logic [3:0] OP_FIRE_LO = 4'd4;
  localparam logic [3:0] OP_FIRE_HI = 4'd5;
  localparam logic [3:0] OP_IRQ     = 4'd6;
  localparam logic [3:0] OP_JMP_LO  = 4'd7;
  localparam logic [3:0] OP_JMP_HI  = 4'd8;
  localparam logic [3:0] OP_LOOP_LO = 4'd9;
  localparam logic [3:0] OP_LOOP_HI = 4'd10;

  localparam logic [4:0] A_CTRL   = 5'd8;
  localparam logic [4:0] A_T0LIM  = 5'd9;
  localparam logic [4:0] A_T1LIM  = 5'd10;
  localparam logic [4:0] A_LPLIM  = 5'd11;
  localparam logic [4:0] A_TCFG   = 5'd12;
  localparam logic [4:0] A_WDLIM  = 5'd13;
  localparam logic [4:0] A_STATUS = 5'd14;
endpackage

// File: rtl/trig_seq_queue.sv
module trig_seq_queue #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int WAW = AW - 2
) (
  input  logic           clk,
  input  logic           we,
  input  logic [WAW-1:0] waddr,
  input  logic [31:0]    wdata,
  input  logic [AW-1:0]  raddr,
  output logic [7:0]     rentry,
  input  logic [WAW-1:0] wrd_addr,
  output logic [31:0]    rword
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < 4; l++) mem[{waddr, 2'(l)}] <= wdata[8*l +: 8];
    end
  end

  assign rentry = mem[raddr];

  generate
    for (genvar l = 0; l < 4; l++) begin : g_lane
      assign rword[8*l +: 8] = mem[{wrd_addr, 2'(l)}];
    end
  endgenerate
endmodule

// File: rtl/trig_seq_cond.sv
module trig_seq_cond #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hw,
  input  logic [N-1:0] edge_sel,
  input  logic [N-1:0] invert,
  output logic [N-1:0] ev
);
  logic [N-1:0] act, prev;
  assign act = hw ^ invert;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= act;
  end

  assign ev = (edge_sel & act & ~prev) | (~edge_sel & act);
endmodule

// File: rtl/trig_seq_pulse.sv
module trig_seq_pulse #(
  parameter int N = 32,
  parameter int PWW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   fire,
  input  logic [PWW-1:0] width_code,
  output logic [N-1:0]   line
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_line
      logic [PWW:0] cnt;
      always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (fire[i])       cnt <= {1'b0, width_code} + (PWW+1)'(1);
        else if (cnt != '0)     cnt <= cnt - (PWW+1)'(1);
      end
      assign line[i] = (cnt != '0);
      assert_pulse_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        fire[i] |=> line[i]);
    end
  endgenerate
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int QDEPTH  = 32,
  parameter int NUM_HW  = 16,
  parameter int NUM_OUT = 32,
  parameter int NUM_IRQ = 16,
  parameter int CW      = 16,
  parameter int PWW     = 2,
  localparam int QAW    = $clog2(QDEPTH),
  localparam int HALF   = NUM_OUT / 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [4:0]         wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [4:0]         rd_addr,
  output logic [31:0]        rd_data,
  input  logic [NUM_HW-1:0]  hw_trig,
  input  logic               sw_trig,
  output logic [NUM_OUT-1:0] trig_out,
  output logic [NUM_IRQ-1:0] irq_out,
  output logic               step_irq,
  output logic               wdog_irq
);
  logic on_q, start_q, sstep_q;
  logic [PWW-1:0] pw_q;
  logic [CW-1:0] tlim_q [2];
  logic [CW-1:0] tcnt_q [2];
  logic [CW-1:0] llim_q, lcnt_q, wdlim_q, wd_q;
  logic [NUM_HW-1:0] edge_q, inv_q;
  logic [QAW-1:0] ptr_q, nxt;
  logic [NUM_IRQ-1:0] irq_q, irq_n;
  logic step_q, wdog_q;
  logic [31:0] rd_q, qword;
  logic [7:0] cur;
  logic [3:0] op, opt;
  logic [NUM_HW-1:0] ev;
  logic [NUM_OUT-1:0] fire, fire_g;
  logic running, done, is_wait, tsel, t_hit, l_hit, q_we;

  assign running = on_q & start_q;
  assign q_we = wr_en & ~running & (wr_addr[4:3] == 2'b00);

  trig_seq_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk(clk), .we(q_we), .waddr(wr_addr[QAW-3:0]), .wdata(wr_data),
    .raddr(ptr_q), .rentry(cur), .wrd_addr(rd_addr[QAW-3:0]), .rword(qword));

  trig_seq_cond #(.N(NUM_HW)) u_cond (
    .clk(clk), .rst(rst), .hw(hw_trig), .edge_sel(edge_q), .invert(inv_q), .ev(ev));

  trig_seq_pulse #(.N(NUM_OUT), .PWW(PWW)) u_pulse (
    .clk(clk), .rst(rst), .fire(fire_g), .width_code(pw_q), .line(trig_out));

  assign op   = cur[7:4];
  assign opt  = cur[3:0];
  assign tsel = opt[0];
  assign t_hit = (tcnt_q[tsel] == tlim_q[tsel]);
  assign l_hit = (lcnt_q == llim_q);
  assign is_wait = (op == OP_WAIT_HW) || (op == OP_WAIT_SW);

  always_comb begin
    done  = 1'b1;
    nxt   = ptr_q + QAW'(1);
    fire  = '0;
    irq_n = '0;
    case (op)
      OP_WAIT_HW: done = ev[opt];
      OP_WAIT_SW: done = sw_trig;
      OP_TWAIT:   done = t_hit;
      OP_FIRE_LO: fire[int'(opt)] = 1'b1;
      OP_FIRE_HI: fire[HALF + int'(opt)] = 1'b1;
      OP_IRQ:     irq_n[opt] = 1'b1;
      OP_JMP_LO:  nxt = QAW'({1'b0, opt});
      OP_JMP_HI:  nxt = QAW'({1'b1, opt});
      OP_LOOP_LO: if (!l_hit) nxt = QAW'({1'b0, opt});
      OP_LOOP_HI: if (!l_hit) nxt = QAW'({1'b1, opt});
      default: ;
    endcase
  end

  assign fire_g = running ? fire : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q <= 1'b0; start_q <= 1'b0; sstep_q <= 1'b0; pw_q <= '0;
      tlim_q[0] <= '0; tlim_q[1] <= '0; tcnt_q[0] <= '0; tcnt_q[1] <= '0;
      llim_q <= '0; lcnt_q <= '0; wdlim_q <= '0; wd_q <= '0;
      edge_q <= '0; inv_q <= '0; ptr_q <= '0;
      irq_q <= '0; step_q <= 1'b0; wdog_q <= 1'b0;
    end else begin
      irq_q <= '0; step_q <= 1'b0; wdog_q <= 1'b0;
      if (!on_q) begin
        ptr_q <= '0; tcnt_q[0] <= '0; tcnt_q[1] <= '0; lcnt_q <= '0; wd_q <= '0;
      end else if (running) begin
        if (op == OP_TWAIT) tcnt_q[tsel] <= t_hit ? '0 : tcnt_q[tsel] + CW'(1);
        if (op == OP_LOOP_LO || op == OP_LOOP_HI) lcnt_q <= l_hit ? '0 : lcnt_q + CW'(1);
        if (done) begin
          ptr_q <= nxt;
          wd_q  <= '0;
          irq_q <= irq_n;
          if (sstep_q) begin start_q <= 1'b0; step_q <= 1'b1; end
        end else if (is_wait) begin
          if (wdlim_q != '0 && wd_q == wdlim_q) begin
            wdog_q <= 1'b1; start_q <= 1'b0; wd_q <= '0;
          end else begin
            wd_q <= wd_q + CW'(1);
          end
        end
      end
      if (wr_en) begin
        if (running) begin
          if (wr_addr == A_CTRL && !wr_data[0]) begin on_q <= 1'b0; start_q <= 1'b0; end
        end else begin
          case (wr_addr)
            A_CTRL: begin
              on_q    <= wr_data[0];
              start_q <= wr_data[1] & wr_data[0] & on_q;
              sstep_q <= wr_data[2];
              pw_q    <= wr_data[4 +: PWW];
            end
            A_T0LIM: tlim_q[0] <= wr_data[CW-1:0];
            A_T1LIM: tlim_q[1] <= wr_data[CW-1:0];
            A_LPLIM: llim_q    <= wr_data[CW-1:0];
            A_TCFG:  begin edge_q <= wr_data[NUM_HW-1:0]; inv_q <= wr_data[16 +: NUM_HW]; end
            A_WDLIM: wdlim_q   <= wr_data[CW-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      rd_q <= '0;
      case (rd_addr)
        A_CTRL:   begin rd_q[0] <= on_q; rd_q[1] <= start_q; rd_q[2] <= sstep_q; rd_q[4 +: PWW] <= pw_q; end
        A_T0LIM:  rd_q[CW-1:0] <= tlim_q[0];
        A_T1LIM:  rd_q[CW-1:0] <= tlim_q[1];
        A_LPLIM:  rd_q[CW-1:0] <= llim_q;
        A_TCFG:   begin rd_q[NUM_HW-1:0] <= edge_q; rd_q[16 +: NUM_HW] <= inv_q; end
        A_WDLIM:  rd_q[CW-1:0] <= wdlim_q;
        A_STATUS: begin rd_q[QAW-1:0] <= ptr_q; rd_q[8] <= on_q; rd_q[9] <= start_q; rd_q[10] <= sstep_q; end
        default:  if (rd_addr[4:3] == 2'b00) rd_q <= qword;
      endcase
    end
  end

  assign rd_data  = rd_q;
  assign irq_out  = irq_q;
  assign step_irq = step_q;
  assign wdog_irq = wdog_q;

  assert_irq_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_out));
  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (rst)
    !on_q |=> (ptr_q == '0));
  assert_locked_limit_R9: assert property (@(posedge clk) disable iff (rst)
    (running && wr_en && wr_addr == A_T0LIM) |=> $stable(tlim_q[0]));
  assert_step_halts_R10: assert property (@(posedge clk) disable iff (rst)
    step_irq |-> !start_q);
  assert_wdog_halts_R11: assert property (@(posedge clk) disable iff (rst)
    wdog_irq |-> !start_q);
endmodule

// File: tb/test_trig_seq.sv
module test_trig_seq;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [15:0] hw_trig = '0;
  logic sw_trig = 1'b0;
  logic [31:0] trig_out;
  logic [15:0] irq_out;
  logic step_irq, wdog_irq;
  int checks = 0, errors = 0, cyc = 0;
  int cnt_irq1 = 0, cnt_irq5 = 0, cnt_step = 0, cnt_wdog = 0;
  int rise3 = -1, rise18 = -1;
  logic done_flag = 1'b0;

  always #4 clk = ~clk;

  trig_seq i_trig_seq (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .hw_trig(hw_trig),
    .sw_trig(sw_trig), .trig_out(trig_out), .irq_out(irq_out),
    .step_irq(step_irq), .wdog_irq(wdog_irq));

  // behavioural reference model
  int mq[32];
  int mtl[2], mt[2];
  int mll, mlc, mwdl, mwd, mptr, mpw;
  int mpc[32];
  logic [15:0] medge, mpol, mprev, mev, mirq;
  logic mon, mstart, msstep, mstep, mwdog;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      foreach (mq[i]) mq[i] = 0;
      foreach (mpc[i]) mpc[i] = 0;
      mtl = '{0, 0}; mt = '{0, 0};
      mll = 0; mlc = 0; mwdl = 0; mwd = 0; mptr = 0; mpw = 0;
      medge = 0; mpol = 0; mprev = 0; mirq = 0;
      mon = 0; mstart = 0; msstep = 0; mstep = 0; mwdog = 0;
    end else begin
      logic [31:0] nf;
      logic run;
      int op, opt, nxt, sel;
      logic dn;
      for (int i = 0; i < 16; i++) begin
        logic a;
        a = hw_trig[i] ^ mpol[i];
        mev[i] = medge[i] ? (a && !mprev[i]) : a;
        mprev[i] = a;
      end
      nf = 0; mirq = 0; mstep = 0; mwdog = 0;
      run = mon && mstart;
      if (!mon) begin
        mptr = 0; mt = '{0, 0}; mlc = 0; mwd = 0;
      end else if (run) begin
        op = mq[mptr] / 16; opt = mq[mptr] % 16; dn = 1; nxt = (mptr + 1) % 32;
        case (op)
          1: dn = mev[opt];
          2: dn = sw_trig;
          3: begin sel = opt % 2; if (mt[sel] == mtl[sel]) mt[sel] = 0; else begin mt[sel]++; dn = 0; end end
          4: nf[opt] = 1;
          5: nf[16 + opt] = 1;
          7: nxt = opt;
          8: nxt = 16 + opt;
          9, 10: if (mlc == mll) mlc = 0; else begin mlc++; nxt = opt + (op == 10 ? 16 : 0); end
          default: ;
        endcase
        if (dn) begin
          mptr = nxt; mwd = 0;
          if (op == 6) mirq[opt] = 1;
          if (msstep) begin mstart = 0; mstep = 1; end
        end else if (op == 1 || op == 2) begin
          if (mwdl != 0 && mwd == mwdl) begin mwdog = 1; mstart = 0; mwd = 0; end
          else mwd++;
        end
      end
      for (int i = 0; i < 32; i++) begin
        if (nf[i]) mpc[i] = mpw + 1;
        else if (mpc[i] > 0) mpc[i]--;
      end
      if (wr_en) begin
        if (run) begin
          if (wr_addr == 8 && !wr_data[0]) begin mon = 0; mstart = 0; end
        end else if (wr_addr < 8) begin
          for (int l = 0; l < 4; l++) mq[wr_addr*4 + l] = int'(wr_data[8*l +: 8]);
        end else begin
          case (wr_addr)
            8: begin mstart = wr_data[1] && wr_data[0] && mon; mon = wr_data[0];
                 msstep = wr_data[2]; mpw = int'(wr_data[5:4]); end
            9: mtl[0] = int'(wr_data[15:0]);
            10: mtl[1] = int'(wr_data[15:0]);
            11: mll = int'(wr_data[15:0]);
            12: begin medge = wr_data[15:0]; mpol = wr_data[31:16]; end
            13: mwdl = int'(wr_data[15:0]);
            default: ;
          endcase
        end
      end
    end
  end

  // compare every clock, half a cycle after the edge
  always @(negedge clk) begin
    if (!rst) begin
      logic [31:0] et;
      for (int i = 0; i < 32; i++) et[i] = (mpc[i] != 0);
      checks += 4;
      if (trig_out !== et) begin errors++; $display("FAIL R5 trig_out actual %h expected %h cycle %0d", trig_out, et, cyc); end
      if (irq_out !== mirq) begin errors++; $display("FAIL R6 irq_out actual %h expected %h cycle %0d", irq_out, mirq, cyc); end
      if (step_irq !== mstep) begin errors++; $display("FAIL R10 step_irq actual %b expected %b cycle %0d", step_irq, mstep, cyc); end
      if (wdog_irq !== mwdog) begin errors++; $display("FAIL R11 wdog_irq actual %b expected %b cycle %0d", wdog_irq, mwdog, cyc); end
      if (irq_out[1]) cnt_irq1++;
      if (irq_out[5]) cnt_irq5++;
      if (step_irq) cnt_step++;
      if (wdog_irq) cnt_wdog++;
      if (trig_out[3] && rise3 < 0) rise3 = cyc;
      if (trig_out[18] && rise18 < 0) rise18 = cyc;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin errors++; $display("FAIL %s actual %h expected %h", req, act, exp); end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(5'd14, v); chk("R13 status after reset", v, 32'h0);
    chk("R13 outputs after reset", {trig_out[15:0], irq_out}, 32'h0);

    // program: fire3, irq5, t0 wait, fire18, wait hw1, t1 wait, irq1, loop->6, wait sw, jmp 0
    wr(5'd0, 32'h52_30_65_43);
    wr(5'd1, 32'h96_61_31_11);
    wr(5'd2, 32'h00_00_70_20);
    for (int k = 3; k < 8; k++) wr(5'(k), 32'h0);
    rd(5'd1, v); chk("R1 queue word readback", v, 32'h96_61_31_11);
    wr(5'd9, 32'd5); wr(5'd10, 32'd3); wr(5'd11, 32'd2);
    wr(5'd12, 32'h0000_0002);
    wr(5'd13, 32'd0);
    wr(5'd8, 32'h13);
    rd(5'd14, v); chk("R8 on and start together", v, 32'h100);
    wr(5'd8, 32'h13);
    idle(20);
    rd(5'd14, v); chk("R2 stalled on hardware wait", v, 32'h304);
    chk("R4 timer delay between pulses", 32'(rise18 - rise3), 32'd8);
    @(negedge clk); hw_trig[1] = 1'b1;
    @(negedge clk); hw_trig[1] = 1'b0;
    idle(30);
    rd(5'd14, v); chk("R3 stalled on software wait", v, 32'h308);
    @(negedge clk); sw_trig = 1'b1;
    @(negedge clk); sw_trig = 1'b0;
    idle(30);
    rd(5'd14, v); chk("R12 back at wait after jump", v, 32'h304);
    chk("R7 loop body count", 32'(cnt_irq1), 32'd3);
    chk("R6 irq5 count", 32'(cnt_irq5), 32'd2);
    wr(5'd9, 32'd100);
    wr(5'd0, 32'hFFFF_FFFF);
    wr(5'd8, 32'h0);
    rd(5'd9, v); chk("R9 limit write ignored while running", v, 32'd5);
    rd(5'd0, v); chk("R9 queue write ignored while running", v, 32'h52_30_65_43);
    rd(5'd14, v); chk("R8 disable clears pointer", v, 32'h0);

    // watchdog: NOPs then level wait on inverted input 2
    wr(5'd0, 32'h12_00_00_00);
    for (int k = 1; k < 8; k++) wr(5'(k), 32'h0);
    wr(5'd12, 32'h0004_0000);
    wr(5'd13, 32'd10);
    @(negedge clk); hw_trig[2] = 1'b1;
    wr(5'd8, 32'h1); wr(5'd8, 32'h3);
    idle(40);
    rd(5'd14, v); chk("R11 halted on stalled command", v, 32'h103);
    chk("R11 one watchdog pulse", 32'(cnt_wdog), 32'd1);
    @(negedge clk); hw_trig[2] = 1'b0;
    wr(5'd8, 32'h3);
    idle(50);
    chk("R2 level wait passes", 32'(cnt_wdog), 32'd1);
    wr(5'd8, 32'h0);

    // single step with wrap
    wr(5'd0, 32'h0000_008F);
    wr(5'd8, 32'h5);
    wr(5'd8, 32'h7);
    idle(3);
    rd(5'd14, v); chk("R10 one step to 31", v, 32'h51F);
    wr(5'd8, 32'h7);
    idle(3);
    rd(5'd14, v); chk("R12 pointer wraps to 0", v, 32'h500);
    chk("R10 step pulses", 32'(cnt_step), 32'd2);
    wr(5'd8, 32'h0);
    idle(5);
    done_flag = 1'b1;
  end

  initial begin
    fork
      begin wait (done_flag); end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog timeout actual hung expected finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule